// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Register Slave

This block sits on the external bus of a small microcontroller. On that bus the low address byte and the data byte share one 8-bit bidirectional port, and the high address byte has a port of its own. The block recovers the full 16-bit address from each bus cycle. It serves read and write strobes against a 16-entry register file that is mapped at a parameterized base address.

The address strobe and the active-low read and write strobes all enter through a multi-stage synchronizer on the system clock. Edges are found by comparing successive synchronized samples, so no strobe ever acts as a clock. The port value travels down a delay pipeline that matches the synchronizer. When the falling address-strobe edge is detected, the block therefore stores the sample that was on the port while the strobe was still high.

A parameter selects one of two capture variants:
- **Edge variant:** the address register is loaded once, at the falling strobe edge.
- **Transparent variant:** the address register follows the port while the strobe is high and freezes when it drops.

The pads are outside this block. The shared port is presented as a separate input, output and output-enable.

Top module: `mux_bus_slave`

## Requirements
- R1: While `rst` is high, and after it is released, `cur_addr` reads 0, `ad_oe` is 0, and every register in the file reads back 0.
- R2: In the edge variant (`CAP_MODE = CAP_EDGE`), `cur_addr` takes `{addr_hi, ad_in}` as they were while `ale` was high, within 4 clocks of `ale` falling. While `ale` is high, `cur_addr` keeps its previous value.
- R3: After capture, `cur_addr` holds its value while `ad_in` changes to data, through the rest of the bus cycle.
- R4: On a falling edge of `wr_n` with `rd_n` high, the byte on `ad_in` is written to register `cur_addr - BASE`, provided the address is in the window.
- R5: While `rd_n` is low, `wr_n` is high and the address is in the window, `ad_oe` is 1 and `ad_out` carries the addressed register, within 4 clocks. Otherwise `ad_oe` is 0.
- R6: The window is `BASE` to `BASE + 15`, with `BASE` a multiple of 16. A bus cycle outside it neither drives `ad_oe` nor changes any register.
- R7: When `rd_n` and `wr_n` are low together, `ad_oe` stays 0 and no register is written.
- R8: In the transparent variant (`CAP_MODE = CAP_LEVEL`), `cur_addr` follows `{addr_hi, ad_in}` while `ale` is high, with a delay of 4 clocks or less. Once `ale` is low, it holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous active-high reset |
| ale | input | 1 | Address strobe, high while the shared port carries the low address |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr_hi | input | 8 | Dedicated high address byte |
| ad_in | input | 8 | Shared port, value seen at the pad |
| ad_out | output | 8 | Shared port, read data to drive |
| ad_oe | output | 1 | Shared port output enable |
| cur_addr | output | 16 | Captured 16-bit bus address |

## Verification
The embedded assertions check four things on every clock:
- a drive enable only ever occurs with a decoded address in the window;
- the port is never enabled while both strobes are low;
- every write strobe lands its byte in the selected register on the next clock;
- the edge variant changes its captured address only on a detected strobe fall.

Some behaviour can only be shown by the bench's scenarios. These include the alignment between the synchronizer and the port pipeline, meaning the right byte is captured although the port turns to data soon after. They also include read-back through a full bus cycle, the absence of writes outside the window or under conflicting strobes, and the transparent variant tracking the port while the strobe is high.

// File: rtl/mux_bus_pkg.sv
package mux_bus_pkg;
   typedef enum logic {
      CAP_EDGE  = 1'b0,
      CAP_LEVEL = 1'b1
   } cap_mode_e;
endpackage

// File: rtl/mbs_sync.sv
module mbs_sync #(
   parameter int unsigned     STAGES  = 2,
   parameter int unsigned     WIDTH   = 3,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout,
   output logic [WIDTH-1:0] dout_prev
);
   logic [WIDTH-1:0] chain [STAGES];

   if (STAGES < 2) begin : g_bad_stages
      $error("mbs_sync: STAGES must be at least 2");
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or posedge rst) begin
         if (rst) chain[s] <= RST_VAL;
         else if (s == 0) chain[s] <= din;
         else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) dout_prev <= RST_VAL;
      else     dout_prev <= chain[STAGES-1];
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/mbs_addr_capture.sv
module mbs_addr_capture
   import mux_bus_pkg::*;
#(
   parameter int unsigned AW       = 16,
   parameter int unsigned STAGES   = 2,
   parameter cap_mode_e   CAP_MODE = CAP_EDGE
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [AW-1:0] bus_addr,
   input  logic          ale_s,
   input  logic          ale_prev,
   output logic [AW-1:0] port_prev,
   output logic [AW-1:0] addr_q
);
   localparam int unsigned DEPTH = STAGES + 1;

   logic [AW-1:0] pipe [DEPTH];
   logic          ale_fall;

   for (genvar k = 0; k < DEPTH; k++) begin : g_pipe
      always_ff @(posedge clk or posedge rst) begin
         if (rst) pipe[k] <= '0;
         else if (k == 0) pipe[k] <= bus_addr;
         else pipe[k] <= pipe[(k == 0) ? 0 : k-1];
      end
   end

   assign ale_fall  = ale_prev & ~ale_s;
   assign port_prev = pipe[DEPTH-1];

   if (CAP_MODE == CAP_EDGE) begin : g_edge
      always_ff @(posedge clk or posedge rst) begin
         if (rst)           addr_q <= '0;
         else if (ale_fall) addr_q <= pipe[DEPTH-1];
      end

      // R2
      edge_capture_chk: assert property (@(posedge clk) disable iff (rst)
         ale_fall |=> addr_q == $past(pipe[DEPTH-1]));
      // R3
      addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
         !ale_fall |=> $stable(addr_q));
   end else begin : g_level
      always_ff @(posedge clk or posedge rst) begin
         if (rst)        addr_q <= '0;
         else if (ale_s) addr_q <= pipe[DEPTH-2];
      end

      // R8
      level_hold_chk: assert property (@(posedge clk) disable iff (rst)
         !ale_s |=> $stable(addr_q));
   end
endmodule

// File: rtl/mbs_regfile.sv
module mbs_regfile #(
   parameter int unsigned DW    = 8,
   parameter int unsigned DEPTH = 16,
   localparam int unsigned IW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          we,
   input  logic [IW-1:0] idx,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] mem [DEPTH];

   if ((1 << IW) != DEPTH) begin : g_bad_depth
      $error("mbs_regfile: DEPTH must be a power of two");
   end

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      always_ff @(posedge clk or posedge rst) begin
         if (rst) mem[e] <= '0;
         else if (we && idx == IW'(e)) mem[e] <= wdata;
      end
   end

   assign rdata = mem[idx];

   // R4
   write_land_chk: assert property (@(posedge clk) disable iff (rst)
      we |=> mem[$past(idx)] == $past(wdata));
endmodule

// File: rtl/mux_bus_slave.sv
module mux_bus_slave
   import mux_bus_pkg::*;
#(
   parameter int unsigned DW       = 8,
   parameter int unsigned HW       = 8,
   parameter int unsigned REGS     = 16,
   parameter int unsigned BASE     = 'h8000,
   parameter int unsigned STAGES   = 2,
   parameter cap_mode_e   CAP_MODE = CAP_EDGE
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          ale,
   input  logic          rd_n,
   input  logic          wr_n,
   input  logic [HW-1:0] addr_hi,
   input  logic [DW-1:0] ad_in,
   output logic [DW-1:0] ad_out,
   output logic          ad_oe,
   output logic [HW+DW-1:0] cur_addr
);
   localparam int unsigned AW = HW + DW;
   localparam int unsigned IW = $clog2(REGS);
   localparam logic [AW-1:0] BASE_V = AW'(BASE);

   if (BASE % REGS != 0) begin : g_bad_base
      $error("mux_bus_slave: BASE must be aligned to REGS");
   end
   if (IW >= AW) begin : g_bad_regs
      $error("mux_bus_slave: REGS too large for address width");
   end

   logic [2:0]    strb_s, strb_p;
   logic          ale_s, ale_p, rd_s, wr_s, wr_p;
   logic [AW-1:0] port_prev;
   logic          hit, wr_fall, we;
   logic [DW-1:0] rdata;

   mbs_sync #(.STAGES(STAGES), .WIDTH(3), .RST_VAL(3'b110)) u_sync (
      .clk(clk), .rst(rst), .din({rd_n, wr_n, ale}),
      .dout(strb_s), .dout_prev(strb_p)
   );

   assign ale_s = strb_s[0];
   assign ale_p = strb_p[0];
   assign wr_s  = strb_s[1];
   assign wr_p  = strb_p[1];
   assign rd_s  = strb_s[2];

   mbs_addr_capture #(.AW(AW), .STAGES(STAGES), .CAP_MODE(CAP_MODE)) u_cap (
      .clk(clk), .rst(rst), .bus_addr({addr_hi, ad_in}),
      .ale_s(ale_s), .ale_prev(ale_p),
      .port_prev(port_prev), .addr_q(cur_addr)
   );

   assign hit     = cur_addr[AW-1:IW] == BASE_V[AW-1:IW];
   assign wr_fall = wr_p & ~wr_s;
   assign we      = wr_fall & rd_s & hit;

   mbs_regfile #(.DW(DW), .DEPTH(REGS)) u_rf (
      .clk(clk), .rst(rst), .we(we), .idx(cur_addr[IW-1:0]),
      .wdata(port_prev[DW-1:0]), .rdata(rdata)
   );

   assign ad_oe  = ~rd_s & wr_s & hit;
   assign ad_out = rdata;

   // R6
   drive_window_chk: assert property (@(posedge clk) disable iff (rst)
      ad_oe |-> cur_addr[AW-1:IW] == BASE_V[AW-1:IW]);
   // R7
   conflict_nodrive_chk: assert property (@(posedge clk) disable iff (rst)
      (!rd_s && !wr_s) |-> !ad_oe);
   // R7
   conflict_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
      !rd_s |-> !we);
endmodule

// File: tb/test_mux_bus_slave.sv
module test_mux_bus_slave;
   import mux_bus_pkg::*;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        ale = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
   logic [7:0]  addr_hi = '0, ad_in = '0;
   logic [7:0]  ad_out, lv_out;
   logic        ad_oe, lv_oe;
   logic [15:0] cur_addr, lv_addr;
   int          checks = 0, errors = 0;

   always #4 clk = ~clk;

   mux_bus_slave #(.BASE('h8000), .CAP_MODE(CAP_EDGE)) i_mux_bus_slave (
      .clk(clk), .rst(rst), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
      .addr_hi(addr_hi), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
      .cur_addr(cur_addr)
   );

   mux_bus_slave #(.BASE('h8000), .CAP_MODE(CAP_LEVEL)) i_mux_bus_slave_lvl (
      .clk(clk), .rst(rst), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
      .addr_hi(addr_hi), .ad_in(ad_in), .ad_out(lv_out), .ad_oe(lv_oe),
      .cur_addr(lv_addr)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic addr_phase(input logic [15:0] a);
      addr_hi = a[15:8];
      ad_in   = a[7:0];
      ale     = 1'b1;
      wait_clk(5);
      ale = 1'b0;
      wait_clk(5);
   endtask

   task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
      addr_phase(a);
      ad_in = d;
      wait_clk(4);
      wr_n = 1'b0;
      wait_clk(6);
      wr_n = 1'b1;
      wait_clk(6);
   endtask

   task automatic bus_read(input logic [15:0] a, output logic [7:0] d, output logic oe);
      addr_phase(a);
      ad_in = 8'hEE;
      rd_n  = 1'b0;
      wait_clk(5);
      d  = ad_out;
      oe = ad_oe;
      rd_n = 1'b1;
      wait_clk(5);
   endtask

   task automatic t_reset;
      logic [7:0] d; logic oe;
      check(cur_addr == 16'h0, "R1 addr", cur_addr, 0);
      check(ad_oe == 1'b0, "R1 oe", ad_oe, 0);
      bus_read(16'h8003, d, oe);
      check(oe && d == 8'h00, "R1 reg zero", d, 0);
      check(ad_oe == 1'b0, "R5 released", ad_oe, 0);
   endtask

   task automatic t_capture;
      addr_hi = 8'h12; ad_in = 8'h34; ale = 1'b1;
      wait_clk(5);
      check(cur_addr == 16'h8003, "R2 no change while ale high", cur_addr, 16'h8003);
      ale = 1'b0;
      wait_clk(4);
      check(cur_addr == 16'h1234, "R2 capture", cur_addr, 16'h1234);
      ad_in = 8'hA5; addr_hi = 8'h77;
      wait_clk(6);
      check(cur_addr == 16'h1234, "R3 hold", cur_addr, 16'h1234);
   endtask

   task automatic t_write_read;
      logic [7:0] d; logic oe;
      bus_write(16'h8005, 8'h5A);
      bus_write(16'h800F, 8'hC3);
      bus_write(16'h8000, 8'h81);
      bus_read(16'h8005, d, oe);
      check(oe && d == 8'h5A, "R4 reg5", d, 8'h5A);
      bus_read(16'h800F, d, oe);
      check(oe && d == 8'hC3, "R4 reg15", d, 8'hC3);
      bus_read(16'h8000, d, oe);
      check(oe && d == 8'h81, "R5 reg0", d, 8'h81);
   endtask

   task automatic t_window;
      logic [7:0] d; logic oe;
      bus_write(16'h8010, 8'hFF);
      bus_write(16'h0005, 8'hFF);
      bus_read(16'h8010, d, oe);
      check(oe == 1'b0, "R6 no drive above", oe, 0);
      bus_read(16'h7FFF, d, oe);
      check(oe == 1'b0, "R6 no drive below", oe, 0);
      bus_read(16'h8000, d, oe);
      check(oe && d == 8'h81, "R6 reg0 untouched", d, 8'h81);
      bus_read(16'h8005, d, oe);
      check(oe && d == 8'h5A, "R6 reg5 untouched", d, 8'h5A);
   endtask

   task automatic t_conflict;
      logic [7:0] d; logic oe;
      addr_phase(16'h8005);
      ad_in = 8'h11;
      wait_clk(3);
      rd_n = 1'b0; wr_n = 1'b0;
      wait_clk(5);
      check(ad_oe == 1'b0, "R7 no drive", ad_oe, 0);
      rd_n = 1'b1; wr_n = 1'b1;
      wait_clk(6);
      bus_read(16'h8005, d, oe);
      check(oe && d == 8'h5A, "R7 no write", d, 8'h5A);
   endtask

   task automatic t_level;
      addr_hi = 8'h80; ad_in = 8'h01; ale = 1'b1;
      wait_clk(4);
      check(lv_addr == 16'h8001, "R8 follow a", lv_addr, 16'h8001);
      ad_in = 8'h09;
      wait_clk(4);
      check(lv_addr == 16'h8009, "R8 follow b", lv_addr, 16'h8009);
      ale = 1'b0;
      wait_clk(5);
      ad_in = 8'h44; addr_hi = 8'h00;
      wait_clk(6);
      check(lv_addr == 16'h8009, "R8 hold", lv_addr, 16'h8009);
   endtask

   initial begin
      wait_clk(3);
      check(cur_addr == 16'h0 && ad_oe == 1'b0, "R1 in reset", cur_addr, 0);
      rst = 1'b0;
      wait_clk(2);
      t_reset();
      t_capture();
      t_write_read();
      t_window();
      t_conflict();
      t_level();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule